// File: doc/BRIEF.md
# Multi-Lane Stripe and Merge Unit with Programmable Lane Routing

This block sits between a link adapter layer and a small set of physical serial lanes. On the transmit side it takes one symbol per cycle and deals the symbols out over the active logical lanes. When a full column is gathered (one symbol per active lane), it launches that column on the physical lanes in a single strobe cycle. On the receive side it captures a column from the physical lanes. It then replays the symbols as a single stream, one per cycle, in logical lane order.

During link bring-up the controller loads a routing table and an active lane count. The routing table gives, for each logical lane, the physical lane that carries it. The count sets the striping width and marks which physical lanes stay powered. A load is accepted only while both directions are idle. A table that would put two active logical lanes on one physical lane is refused.

Traffic is expected in whole columns: a stream ends on a multiple of the active count. Receive columns arrive at least as many cycles apart as there are active lanes. A symbol written at logical slot k of the routing field `cfg_map` occupies bits `[k*IDX_W +: IDX_W]`, with `IDX_W` = 2 at the default of four lanes.

Top module: `lane_mapper`

## Requirements
- R1: After reset the active count is 1, logical lane k routes to physical lane k, `lane_en` is 1 only on physical lane 0, and `phy_tx_vld`, `rx_vld`, `cfg_done` and `cfg_bad` are low.
- R2: A `cfg_load` with a valid table and count, sampled while idle, takes effect at that edge, and `cfg_done` is high for exactly the next cycle.
- R3: A load where two active logical lanes (index below the count) name the same physical lane, or name a lane at or above LANES, is refused: `cfg_bad` pulses for one cycle and the routing, count and `lane_en` are unchanged.
- R4: A load with a count of zero or a count above LANES is refused in the same way as R3.
- R5: A load sampled while not idle is ignored with neither `cfg_done` nor `cfg_bad`. Not idle means any of: a partial transmit column is held, `tx_vld` is high, the receive replay is running, or `phy_rx_vld` is high.
- R6: `lane_en[p]` is 1 exactly when some active logical lane routes to physical lane p.
- R7: Transmit symbols fill logical lanes 0, 1, ... N-1 in arrival order, where N is the active count. In the cycle after the edge that samples the N-th symbol, `phy_tx_vld` is high for one cycle, and logical lane k's symbol appears on physical lane map[k].
- R8: Lane data on `phy_tx_data` is zero on every physical lane whose `lane_en` bit is 0, and on all lanes whenever `phy_tx_vld` is low.
- R9: A column sampled with `phy_rx_vld` is replayed on `rx_sym` with `rx_vld` high for N consecutive cycles starting the next cycle. The replay starts with the symbol of logical lane 0, read from physical lane map[0], and proceeds in logical order.
- R10: With `phy_tx_*` wired to `phy_rx_*`, the receive stream equals the transmit stream for every valid count and routing, with or without idle cycles between symbols.
- R11: Routing entries of inactive logical lanes (index at or above the count) are ignored for validation, routing and `lane_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Request to load routing table and count |
| cfg_lanes | input | CNT_W | Requested active lane count |
| cfg_map | input | LANES*IDX_W | Physical lane index per logical lane |
| cfg_done | output | 1 | One-cycle pulse: load applied |
| cfg_bad | output | 1 | One-cycle pulse: load refused as invalid |
| lane_en | output | LANES | Per physical lane enable (0 = off) |
| tx_vld | input | 1 | Transmit symbol valid |
| tx_sym | input | SYM_W | Transmit symbol |
| phy_tx_vld | output | 1 | Column strobe on physical transmit lanes |
| phy_tx_data | output | LANES*SYM_W | Physical transmit lane symbols, lane p at [p*SYM_W +: SYM_W] |
| phy_rx_vld | input | 1 | Column strobe on physical receive lanes |
| phy_rx_data | input | LANES*SYM_W | Physical receive lane symbols |
| rx_vld | output | 1 | Merged receive symbol valid |
| rx_sym | output | SYM_W | Merged receive symbol |

## Verification
A wrong fill pointer or routing register in the transmit path shows up in the first column after the fault, no later than N symbols on. It appears as a symbol on the wrong physical lane or in the wrong slot. A corrupted count or table is visible on `lane_en` in the cycle after the load. A faulty replay pointer in the merge path puts a symbol out of order within N cycles of the next column. A faulty idle gate shows as a stray `cfg_done` pulse and a changed `lane_en` after a load issued mid-column.

// File: rtl/lane_map_pkg.sv
package lane_map_pkg;

   typedef enum logic [1:0] {
      CFG_IGNORE = 2'd0,
      CFG_TAKE   = 2'd1,
      CFG_REFUSE = 2'd2
   } cfg_verdict_e;

   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lane_map_cfg.sv
module lane_map_cfg
   import lane_map_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic [LANES*IDX_W-1:0] map_i,
   input  logic                   idle_i,
   output logic [CNT_W-1:0]       cnt_o,
   output logic [LANES*IDX_W-1:0] map_o,
   output logic [LANES-1:0]       en_o,
   output logic                   done_o,
   output logic                   bad_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LANES);
   localparam logic [IDX_W:0]   IDX_LIM = (IDX_W+1)'(LANES);

   logic             cnt_ok;
   logic             map_ok;
   logic [LANES-1:0] en_next;
   cfg_verdict_e     verdict;

   always_comb begin
      cnt_ok  = (cnt_i != '0) && (cnt_i <= CNT_MAX);
      map_ok  = 1'b1;
      en_next = '0;
      for (int a = 0; a < LANES; a++) begin
         if (CNT_W'(a) < cnt_i) begin
            if ({1'b0, map_i[a*IDX_W +: IDX_W]} >= IDX_LIM)
               map_ok = 1'b0;
            for (int b = a + 1; b < LANES; b++) begin
               if ((CNT_W'(b) < cnt_i) &&
                   (map_i[a*IDX_W +: IDX_W] == map_i[b*IDX_W +: IDX_W]))
                  map_ok = 1'b0;
            end
            en_next[map_i[a*IDX_W +: IDX_W]] = 1'b1;
         end
      end
   end

   always_comb begin
      if (!load_i || !idle_i)     verdict = CFG_IGNORE;
      else if (cnt_ok && map_ok)  verdict = CFG_TAKE;
      else                        verdict = CFG_REFUSE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o  <= CNT_W'(1);
         en_o   <= LANES'(1);
         done_o <= 1'b0;
         bad_o  <= 1'b0;
         for (int l = 0; l < LANES; l++)
            map_o[l*IDX_W +: IDX_W] <= IDX_W'(l);
      end else begin
         done_o <= (verdict == CFG_TAKE);
         bad_o  <= (verdict == CFG_REFUSE);
         if (verdict == CFG_TAKE) begin
            cnt_o <= cnt_i;
            map_o <= map_i;
            en_o  <= en_next;
         end
      end
   end

   // R2
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, bad_o}));

   // R3
   bad_no_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_o |-> ($stable(en_o) && $stable(cnt_o) && $stable(map_o)));

   // R5
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !idle_i) |=> (!done_o && !bad_o && $stable(en_o)));

   // R6
   en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(en_o) == int'(cnt_o));

endmodule

// File: rtl/lane_map_tx.sv
module lane_map_tx #(
   parameter int LANES = 4,
   parameter int SYM_W = 8,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic [LANES*IDX_W-1:0] map_i,
   input  logic                   vld_i,
   input  logic [SYM_W-1:0]       sym_i,
   output logic                   col_vld_o,
   output logic [LANES*SYM_W-1:0] col_o,
   output logic                   empty_o
);

   logic [CNT_W-1:0] fill_q;
   logic [SYM_W-1:0] stage_q [LANES];
   logic [SYM_W-1:0] col_next [LANES];
   logic [SYM_W-1:0] col_q [LANES];
   logic             col_vld_q;
   logic             last;

   assign last    = (fill_q + CNT_W'(1)) == cnt_i;
   assign empty_o = (fill_q == '0);

   always_comb begin
      for (int p = 0; p < LANES; p++)
         col_next[p] = '0;
      for (int l = 0; l < LANES; l++) begin
         if (CNT_W'(l) < cnt_i)
            col_next[map_i[l*IDX_W +: IDX_W]] =
               (CNT_W'(l) == fill_q) ? sym_i : stage_q[l];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= '0;
         col_vld_q <= 1'b0;
         for (int l = 0; l < LANES; l++) begin
            stage_q[l] <= '0;
            col_q[l]   <= '0;
         end
      end else begin
         col_vld_q <= vld_i && last;
         if (vld_i) begin
            stage_q[fill_q[IDX_W-1:0]] <= sym_i;
            fill_q <= last ? '0 : fill_q + CNT_W'(1);
         end
         for (int p = 0; p < LANES; p++)
            col_q[p] <= (vld_i && last) ? col_next[p] : '0;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign col_o[g*SYM_W +: SYM_W] = col_q[g];
   end

   assign col_vld_o = col_vld_q;

   // R7
   col_after_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld_o |-> $past(vld_i));

   // R7
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q < cnt_i);

endmodule

// File: rtl/lane_map_rx.sv
module lane_map_rx #(
   parameter int LANES = 4,
   parameter int SYM_W = 8,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic [LANES*IDX_W-1:0] map_i,
   input  logic                   col_vld_i,
   input  logic [LANES*SYM_W-1:0] col_i,
   output logic                   vld_o,
   output logic [SYM_W-1:0]       sym_o,
   output logic                   busy_o
);

   logic [SYM_W-1:0] lane_in [LANES];
   logic [SYM_W-1:0] hold_q [LANES];
   logic [CNT_W-1:0] rd_q;
   logic             busy_q;

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign lane_in[g] = col_i[g*SYM_W +: SYM_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         busy_q <= 1'b0;
         for (int l = 0; l < LANES; l++)
            hold_q[l] <= '0;
      end else if (col_vld_i) begin
         rd_q   <= '0;
         busy_q <= 1'b1;
         for (int l = 0; l < LANES; l++)
            hold_q[l] <= lane_in[map_i[l*IDX_W +: IDX_W]];
      end else if (busy_q) begin
         if ((rd_q + CNT_W'(1)) == cnt_i) begin
            busy_q <= 1'b0;
            rd_q   <= '0;
         end else begin
            rd_q <= rd_q + CNT_W'(1);
         end
      end
   end

   assign vld_o  = busy_q;
   assign busy_o = busy_q;
   assign sym_o  = busy_q ? hold_q[rd_q[IDX_W-1:0]] : '0;

   // R9
   replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld_i |=> (vld_o && rd_q == '0));

   // R9
   replay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (rd_q < cnt_i));

endmodule

// File: rtl/lane_mapper.sv
module lane_mapper
   import lane_map_pkg::*;
#(
   parameter  int LANES = 4,
   parameter  int SYM_W = 8,
   localparam int IDX_W = idx_bits(LANES),
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_load,
   input  logic [CNT_W-1:0]       cfg_lanes,
   input  logic [LANES*IDX_W-1:0] cfg_map,
   output logic                   cfg_done,
   output logic                   cfg_bad,
   output logic [LANES-1:0]       lane_en,
   input  logic                   tx_vld,
   input  logic [SYM_W-1:0]       tx_sym,
   output logic                   phy_tx_vld,
   output logic [LANES*SYM_W-1:0] phy_tx_data,
   input  logic                   phy_rx_vld,
   input  logic [LANES*SYM_W-1:0] phy_rx_data,
   output logic                   rx_vld,
   output logic [SYM_W-1:0]       rx_sym
);

   if (LANES < 2 || LANES > 8) begin : g_lanes_range
      $error("lane_mapper: LANES must lie in 2..8");
   end
   if (SYM_W < 1) begin : g_sym_range
      $error("lane_mapper: SYM_W must be positive");
   end

   logic [CNT_W-1:0]       act_cnt;
   logic [LANES*IDX_W-1:0] act_map;
   logic                   tx_empty;
   logic                   rx_busy;
   logic                   idle;

   assign idle = tx_empty & ~tx_vld & ~rx_busy & ~phy_rx_vld;

   lane_map_cfg #(.LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cfg_load),
      .cnt_i  (cfg_lanes),
      .map_i  (cfg_map),
      .idle_i (idle),
      .cnt_o  (act_cnt),
      .map_o  (act_map),
      .en_o   (lane_en),
      .done_o (cfg_done),
      .bad_o  (cfg_bad)
   );

   lane_map_tx #(.LANES(LANES), .SYM_W(SYM_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (act_cnt),
      .map_i     (act_map),
      .vld_i     (tx_vld),
      .sym_i     (tx_sym),
      .col_vld_o (phy_tx_vld),
      .col_o     (phy_tx_data),
      .empty_o   (tx_empty)
   );

   lane_map_rx #(.LANES(LANES), .SYM_W(SYM_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (act_cnt),
      .map_i     (act_map),
      .col_vld_i (phy_rx_vld),
      .col_i     (phy_rx_data),
      .vld_o     (rx_vld),
      .sym_o     (rx_sym),
      .busy_o    (rx_busy)
   );

   for (genvar p = 0; p < LANES; p++) begin : g_off_chk
      // R8
      off_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!lane_en[p] || !phy_tx_vld) |-> (phy_tx_data[p*SYM_W +: SYM_W] == '0));
   end

endmodule

// File: tb/sim_lane_mapper.sv
`timescale 1ns/1ps
module sim_lane_mapper;

   localparam int LANES = 4;
   localparam int SYM_W = 8;

   typedef struct packed {
      logic [2:0] cnt;
      logic [7:0] map;
      logic [3:0] en;
      logic       gap;
   } vec_t;

   // count, routing (logical k at [2k+:2]), expected lane enables, idle gaps
   localparam vec_t VEC [6] = '{
      '{3'd4, 8'hE4, 4'b1111, 1'b0},
      '{3'd4, 8'h1B, 4'b1111, 1'b1},
      '{3'd2, 8'hD2, 4'b0101, 1'b0},
      '{3'd1, 8'h93, 4'b1000, 1'b0},
      '{3'd3, 8'h8D, 4'b1011, 1'b1},
      '{3'd2, 8'h57, 4'b1010, 1'b0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_load = 1'b0;
   logic [2:0]       cfg_lanes = '0;
   logic [7:0]       cfg_map = '0;
   logic             cfg_done, cfg_bad;
   logic [3:0]       lane_en;
   logic             tx_vld = 1'b0;
   logic [7:0]       tx_sym = '0;
   logic             phy_tx_vld;
   logic [31:0]      phy_tx_data;
   logic             rx_vld;
   logic [7:0]       rx_sym;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   bit mon_on = 0;

   logic [7:0] sent [0:63];
   int sent_n = 0, col_idx = 0, rx_idx = 0, cur_cnt = 1;
   logic [7:0] cur_map = 8'hE4;

   always #10 clk = ~clk;

   lane_mapper #(.LANES(LANES), .SYM_W(SYM_W)) u0 (
      .clk (clk), .rst_n (rst_n),
      .cfg_load (cfg_load), .cfg_lanes (cfg_lanes), .cfg_map (cfg_map),
      .cfg_done (cfg_done), .cfg_bad (cfg_bad), .lane_en (lane_en),
      .tx_vld (tx_vld), .tx_sym (tx_sym),
      .phy_tx_vld (phy_tx_vld), .phy_tx_data (phy_tx_data),
      .phy_rx_vld (phy_tx_vld), .phy_rx_data (phy_tx_data),
      .rx_vld (rx_vld), .rx_sym (rx_sym)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (phy_tx_vld) begin
            logic [31:0] exp_col;
            exp_col = '0;
            for (int l = 0; l < cur_cnt; l++)
               exp_col[cur_map[l*2 +: 2]*8 +: 8] = sent[col_idx*cur_cnt + l];
            check(phy_tx_data == exp_col, "R7 R8 column placement", phy_tx_data, exp_col);
            col_idx++;
         end else if (phy_tx_data != '0) begin
            check(1'b0, "R8 lanes idle zero", phy_tx_data, 0);
         end
         if (rx_vld) begin
            check(rx_sym == sent[rx_idx], "R9 R10 merged order", rx_sym, sent[rx_idx]);
            rx_idx++;
         end
      end
   end

   task automatic load_cfg(input logic [2:0] c, input logic [7:0] m, input bit exp_done,
                           input bit exp_bad, input logic [3:0] exp_en, input string req);
      @(negedge clk);
      cfg_load = 1'b1; cfg_lanes = c; cfg_map = m;
      @(negedge clk);
      cfg_load = 1'b0;
      check(cfg_done == exp_done && cfg_bad == exp_bad, req,
            {cfg_done, cfg_bad}, {exp_done, exp_bad});
      check(lane_en == exp_en, {req, " lane_en"}, lane_en, exp_en);
   endtask

   task automatic stream(input int n, input bit gap, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_vld = 1'b1;
         tx_sym = 8'(seed + i * 29);
         sent[sent_n] = tx_sym;
         sent_n++;
         if (gap && i[0]) begin
            @(negedge clk);
            tx_vld = 1'b0;
         end
      end
      @(negedge clk);
      tx_vld = 1'b0;
   endtask

   task automatic restart_counts();
      sent_n = 0; col_idx = 0; rx_idx = 0;
   endtask

   task automatic drain_and_count(input string req);
      repeat (8) @(negedge clk);
      check(rx_idx == sent_n, req, rx_idx, sent_n);
      check(col_idx * cur_cnt == sent_n, req, col_idx * cur_cnt, sent_n);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL R10 watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(lane_en == 4'b0001, "R1 reset lane_en", lane_en, 4'b0001);
      check({phy_tx_vld, rx_vld, cfg_done, cfg_bad} == 4'b0, "R1 reset strobes",
            {phy_tx_vld, rx_vld, cfg_done, cfg_bad}, 0);
      mon_on = 1'b1;
      // R1 default single lane, identity route
      restart_counts();
      stream(2, 1'b0, 7);
      drain_and_count("R1 default data path");

      // table walk: R2 R6 R7 R9 R10 R11
      for (int v = 0; v < 6; v++) begin
         load_cfg(VEC[v].cnt, VEC[v].map, 1'b1, 1'b0, VEC[v].en, "R2 R6 R11 load");
         cur_cnt = int'(VEC[v].cnt);
         cur_map = VEC[v].map;
         restart_counts();
         stream(3 * cur_cnt, VEC[v].gap, 13 + v * 41);
         drain_and_count("R10 loopback");
      end

      // R3 duplicate active routing (count 3, lanes 0 and 1 both on 2)
      load_cfg(3'd3, 8'hEA, 1'b0, 1'b1, 4'b1010, "R3 duplicate refused");
      // R4 count out of range
      load_cfg(3'd0, 8'hE4, 1'b0, 1'b1, 4'b1010, "R4 zero count refused");
      load_cfg(3'd5, 8'hE4, 1'b0, 1'b1, 4'b1010, "R4 large count refused");
      // old routing still in force
      restart_counts();
      stream(4, 1'b0, 99);
      drain_and_count("R3 R4 routing kept");

      // R5 load mid-column ignored
      restart_counts();
      stream(1, 1'b0, 201);
      load_cfg(3'd4, 8'hE4, 1'b0, 1'b0, 4'b1010, "R5 busy load ignored");
      stream(1, 1'b0, 150);
      drain_and_count("R5 old routing used");
      // R2 now idle: accepted
      load_cfg(3'd4, 8'hE4, 1'b1, 1'b0, 4'b1111, "R2 idle load");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule